// File: doc/BRIEF.md
# Receive Sample Packet Framer

This block turns a stream of ADC samples into inbound packets for the host. Each packet is a 32-bit word stream with three parts. First comes a header word that carries the logical channel and an overrun status bit. Next comes a timestamp word with the value of a free-running sample counter at the first sample of the packet. The packet ends with a run-time selectable number of payload words, one per sample.

Accepted samples enter a small queue in front of the word emitter. The queue absorbs the two extra words each packet needs and short stalls from the downstream sink. When the queue is full, an arriving sample is discarded. The loss is noted in a sticky flag, which shows up in the next header the block forms.

Top module: `rxf_framer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `out_valid`, `out_sop` and `out_eop` are low, and the sample counter starts again from zero.
- R2: The header word has this layout:
  - bits 31:27 hold the channel present on `chan_id` when the packet's first sample was accepted;
  - bit 3 is the overrun flag;
  - every other bit, including the immediate and burst flags in bits 2:0, is zero.
- R3: A packet is sent in this order:
  - the header, marked with `out_sop`;
  - the timestamp;
  - exactly the packet length of payload words, each equal to the accepted sample (real part in bits 31:16, imaginary in 15:0), with `out_eop` on the last payload word only.
- R4: The timestamp equals the 32-bit sample counter at the clock edge where the packet's first sample was accepted. The counter is zero in the first cycle after reset and increments by one on every clock.
- R5: The packet length is read from `pkt_len` only when a packet's first sample is accepted. Later changes do not affect the packet in progress, and a value of 0 is treated as 1.
- R6: When DEPTH accepted samples are still waiting to be emitted, an arriving sample is discarded. Packets are built only from accepted samples and always have their full length.
- R7: A discarded sample sets a sticky overrun flag. The next header formed after the discard carries bit 3 set, and headers formed after that one carry it clear until a new discard occurs.
- R8: A sample that would start a packet while `chan_id` is 0x1F is ignored. It starts no packet, causes no output and does not set the overrun flag.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; also advances the timestamp counter |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: one sample present this cycle |
| smp_data | input | 32 | Complex sample, real in 31:16, imaginary in 15:0 |
| chan_id | input | 5 | Logical channel for packets started now |
| pkt_len | input | LEN_W | Samples per packet, read at packet start |
| out_ready | input | 1 | Downstream can take a word this cycle |
| out_valid | output | 1 | A word is presented on out_data |
| out_data | output | 32 | Packet word (header, timestamp or payload) |
| out_sop | output | 1 | Presented word is a header |
| out_eop | output | 1 | Presented word is the last payload word |

## Verification
A position counter that slips inside the ingress shows up within the same packet: `out_eop` lands on the wrong payload word, or a header appears where a payload word should be. A timestamp taken on the wrong edge is off by at least one count in the very next timestamp word. An overrun flag that is stuck or cleared early shows in the next one or two headers. A queue that keeps a discarded sample lengthens the packet stream after a stall, and every word that follows comes out shifted.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 5;
    localparam int OVR_BIT = 3;
    localparam logic [CHAN_W-1:0] CTRL_CHAN = 5'h1F;

    typedef struct packed {
        logic              first;
        logic              last;
        logic [CHAN_W-1:0] chan;
        logic [WORD_W-1:0] ts;
        logic [WORD_W-1:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_TS   = 2'd2,
        ST_PAY  = 2'd3
    } emit_state_t;

    localparam logic [WORD_W-1:0] HDR_ZERO_MASK =
        ~({{CHAN_W{1'b1}}, {(WORD_W-CHAN_W){1'b0}}} | (WORD_W'(1) << OVR_BIT));

    function automatic logic [WORD_W-1:0] make_header(input logic [CHAN_W-1:0] chan,
                                                      input logic ovr);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: CHAN_W] = chan;
        w[OVR_BIT] = ovr;
        return w;
    endfunction

endpackage

// File: rtl/rxf_tsctr.sv
module rxf_tsctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // R4
    ts_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    output entry_t head,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t         mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [AW:0]    used;

    assign empty = (used == '0);
    assign full  = (used == (AW+1)'(DEPTH));
    assign head  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/rxf_ingress.sv
module rxf_ingress
    import rxf_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [WORD_W-1:0] ts_now,
    input  logic              fifo_full,
    output logic              push,
    output entry_t            push_entry,
    output logic              drop
);
    logic [LEN_W-1:0] pos_q, len_q, eff_len;
    logic             at_start, reserved, is_last;

    always_comb begin
        at_start = (pos_q == '0);
        if (at_start) eff_len = (pkt_len == '0) ? LEN_W'(1) : pkt_len;
        else          eff_len = len_q;
        reserved = at_start && (chan_id == CTRL_CHAN);
        is_last  = (({1'b0, pos_q} + 1'b1) == {1'b0, eff_len});
        push     = smp_valid && !reserved && !fifo_full;
        drop     = smp_valid && !reserved &&  fifo_full;

        push_entry.first = at_start;
        push_entry.last  = is_last;
        push_entry.chan  = chan_id;
        push_entry.ts    = ts_now;
        push_entry.data  = smp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            len_q <= '0;
        end else if (push) begin
            len_q <= eff_len;
            pos_q <= is_last ? '0 : pos_q + 1'b1;
        end
    end

    // R5
    pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q != '0 |-> pos_q < len_q);

    // R5
    len_held_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q != '0 |=> $stable(len_q) || pos_q == '0 || $past(pos_q) == '0);
endmodule

// File: rtl/rxf_emitter.sv
module rxf_emitter
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  entry_t            head,
    input  logic              empty,
    input  logic              drop,
    input  logic              out_ready,
    output logic              pop,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);
    emit_state_t       state;
    logic [WORD_W-1:0] hdr_q;
    logic              ovr_q;
    logic              capture;

    assign capture = (state == ST_IDLE) && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            hdr_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= (ovr_q && !capture) || drop;
            unique case (state)
                ST_IDLE: if (!empty) begin
                    hdr_q <= make_header(head.chan, ovr_q);
                    state <= ST_HDR;
                end
                ST_HDR:  if (out_ready) state <= ST_TS;
                ST_TS:   if (out_ready) state <= ST_PAY;
                ST_PAY:  if (!empty && out_ready && head.last) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        pop       = 1'b0;
        unique case (state)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_q;
                out_sop   = 1'b1;
            end
            ST_TS: begin
                out_valid = 1'b1;
                out_data  = head.ts;
            end
            ST_PAY: begin
                out_valid = !empty;
                out_data  = head.data;
                out_eop   = !empty && head.last;
                pop       = !empty && out_ready;
            end
            default: ;
        endcase
    end

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_sop) && $stable(out_eop));

    // R2
    hdr_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sop |-> (out_data & HDR_ZERO_MASK) == '0);

    // R8
    hdr_no_ctrl_chan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sop |-> out_data[WORD_W-1 -: CHAN_W] != CTRL_CHAN);

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr_q);

    // R3
    head_is_first_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE && !empty |-> head.first);

    // R3
    single_marker_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_sop && out_eop));
endmodule

// File: rtl/rxf_framer.sv
module rxf_framer
    import rxf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [31:0]       smp_data,
    input  logic [4:0]        chan_id,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              out_sop,
    output logic              out_eop
);
    logic [WORD_W-1:0] ts_now;
    logic              push, pop, drop, empty, full;
    entry_t            push_entry, head;

    rxf_tsctr #(.W(WORD_W)) u_tsctr (
        .clk   (clk),
        .rst   (rst),
        .count (ts_now)
    );

    rxf_ingress #(.LEN_W(LEN_W)) u_ingress (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .chan_id    (chan_id),
        .pkt_len    (pkt_len),
        .ts_now     (ts_now),
        .fifo_full  (full),
        .push       (push),
        .push_entry (push_entry),
        .drop       (drop)
    );

    rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .full       (full)
    );

    rxf_emitter u_emitter (
        .clk       (clk),
        .rst       (rst),
        .head      (head),
        .empty     (empty),
        .drop      (drop),
        .out_ready (out_ready),
        .pop       (pop),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !out_sop && !out_eop);
endmodule

// File: tb/rxf_framer_tb.sv
module rxf_framer_tb;
    localparam int DEPTH = 8;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [31:0]      smp_data = '0;
    logic [4:0]       chan_id = '0;
    logic [LEN_W-1:0] pkt_len = 8'd4;
    logic             out_ready = 1'b0;
    logic             out_valid, out_sop, out_eop;
    logic [31:0]      out_data;

    always #4 clk = ~clk;

    rxf_framer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .chan_id(chan_id), .pkt_len(pkt_len), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop)
    );

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] bcnt = '0;
    logic [33:0] exp_q[$];
    string       tag_q[$];
    int          mpos = 0;
    int          mlen = 1;
    logic        nxt_ovr = 1'b0;

    always @(posedge clk) bcnt <= rst ? 32'd0 : bcnt + 32'd1;

    function automatic logic [31:0] hdr(input logic [4:0] c, input logic o);
        return {c, 23'd0, o, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic sop, input logic eop, input logic [31:0] w,
                            input string tag);
        exp_q.push_back({sop, eop, w});
        tag_q.push_back(tag);
    endtask

    // kind: 0 accepted, 1 dropped (overrun), 2 ignored (control channel)
    task automatic drive_sample(input logic [31:0] d, input int kind);
        if (kind == 0) begin
            if (mpos == 0) begin
                mlen = (pkt_len == 0) ? 1 : int'(pkt_len);
                push_exp(1'b1, 1'b0, hdr(chan_id, nxt_ovr), "R2");
                push_exp(1'b0, 1'b0, bcnt, "R4");
            end
            push_exp(1'b0, mpos == mlen - 1, d, "R3");
            mpos = (mpos == mlen - 1) ? 0 : mpos + 1;
        end
        smp_valid = 1'b1;
        smp_data  = d;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drain;
        while (exp_q.size() != 0) idle(1);
        idle(3);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected word", {30'd0, out_sop, out_eop, out_data}, 64'd0);
            end else begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {30'd0, out_sop, out_eop, out_data}, {30'd0, e});
            end
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        idle(3);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        check("R1 markers after release", {62'd0, out_sop, out_eop}, 64'd0);
        idle(1);
        check("R1 valid after release", {63'd0, out_valid}, 64'd0);
        out_ready = 1'b1;

        // R2 R3 R4: basic packets, channel changed mid-packet
        chan_id = 5'd2; pkt_len = 8'd4;
        for (int i = 0; i < 8; i++) begin
            drive_sample(32'hA000_0000 + i, 0);
            if (i == 0) chan_id = 5'd9;
            idle(3);
        end
        drain();

        // R5: length change mid-packet, then length 0
        chan_id = 5'd7; pkt_len = 8'd3;
        for (int i = 0; i < 3; i++) begin
            drive_sample(32'h5500_0010 + i, 0);
            if (i == 0) pkt_len = 8'd6;
            idle(2);
        end
        pkt_len = 8'd0;
        for (int i = 0; i < 2; i++) begin
            drive_sample(32'h1234_0000 + i, 0);
            idle(4);
        end
        drain();

        // R9: toggling backpressure
        chan_id = 5'd12; pkt_len = 8'd5;
        fork
            begin
                for (int c = 0; c < 80; c++) begin
                    out_ready = (c % 3) != 1;
                    idle(1);
                end
                out_ready = 1'b1;
            end
            begin
                for (int i = 0; i < 10; i++) begin
                    drive_sample({16'(i * 3), 16'hFFFF - 16'(i)}, 0);
                    idle(4);
                end
            end
        join
        drain();

        // R6 R7: stall, overfill, then recover
        out_ready = 1'b0; chan_id = 5'd1; pkt_len = 8'd4;
        for (int i = 0; i < 11; i++) begin
            if (i == 4) nxt_ovr = 1'b1;
            drive_sample(32'hC0DE_0000 + i, (i < DEPTH) ? 0 : 1);
        end
        nxt_ovr = 1'b0;
        idle(2);
        out_ready = 1'b1;
        drain();
        for (int i = 0; i < 4; i++) begin
            drive_sample(32'hBEEF_0000 + i, 0);
            idle(2);
        end
        drain();

        // R8: control channel cannot start a packet
        chan_id = 5'h1F;
        drive_sample(32'hDEAD_BEEF, 2);
        begin
            int seen = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            @(posedge clk); #1;
            check("R8 no output for control channel", 64'(seen), 64'd0);
        end
        chan_id = 5'd5; pkt_len = 8'd2;
        for (int i = 0; i < 2; i++) begin
            drive_sample(32'h0F0F_0000 + i, 0);
            idle(3);
        end
        drain();

        check("R3 scoreboard empty", 64'(exp_q.size()), 64'd0);
        report();
        $finish;
    end
endmodule